// File: doc/BRIEF.md
# Processor-side interrupt acknowledge and completion interface

This block sits between an interrupt distributor and a single processor. Each cycle the distributor presents its best pending candidate: an ID, a priority and, for software-generated interrupts, the number of the CPU that raised it. The block decides whether that candidate may interrupt the processor. The candidate must pass a per-CPU enable and a priority mask. It must also be more urgent than whatever the processor is already servicing. When all of this holds, the block drives the interrupt request line.

Software works through four word registers on a simple read/write port:

| Address | Register | Access |
|---|---|---|
| 0 | control | read/write |
| 1 | priority mask | read/write |
| 2 | acknowledge | read, with side effects |
| 3 | completion | write |

A read of the acknowledge register returns the candidate's combined ID/source value and pushes the candidate onto a running-priority stack. This marks the candidate active and pulses `take_o` toward the distributor. If no candidate qualifies, the read returns the spurious ID 1023 and changes nothing. Writing the acknowledged value back to the completion register retires that interrupt, pulses `done_o`, and restores the previous running priority. Nested preemption is therefore possible up to a parameterised depth.

Top module: `cpu_irq_iface`

## Requirements
- R1: An acknowledge read returns the ID in bits 9:0. Bits 12:10 carry the source CPU when the ID is below 16 and are zero for IDs 16 and above. Bits 31:13 are zero.
- R2: When no candidate qualifies, an acknowledge read returns 1023 (0x3FF) and leaves the running priority and the active stack unchanged.
- R3: A candidate with ID 1020 or above never qualifies, whatever its priority. ID 1019 can qualify.
- R4: A candidate is signalled only when its priority is numerically below the mask. A mask of 0xF0 admits priority 0xA0, and a priority equal to the mask is rejected.
- R5: Bit 0 of the control register (address 0) gates signalling. While it is 0, `irq_o` stays low and an acknowledge read returns 1023.
- R6: `irq_o` is high exactly when a valid, enabled, unmasked candidate has a priority numerically below the running priority. The running priority is 0xFF when nothing is active.
- R7: A successful acknowledge read (address 2) pulses `take_o` in that cycle, and the candidate's priority becomes the running priority. A candidate of equal priority then no longer raises `irq_o`.
- R8: A completion write (address 3) whose bits 12:0 equal the most recently acknowledged, still-active value, with bits 31:13 zero, retires it. It pulses `done_o` and restores the previous running priority.
- R9: A completion write that does not match the most recent active value, or is made while nothing is active, is ignored.
- R10: At most DEPTH (default 4) interrupts are active at once. With the stack full, `irq_o` stays low and an acknowledge read returns 1023.
- R11: After reset the enable is 0, the mask is 0x00, nothing is active, `irq_o` is low and `reg_rdata` is 0.
- R12: Reads of address 0 return the enable in bit 0, reads of address 1 return the mask in bits 7:0, and reads of address 3 return 0. Read data appears on `reg_rdata` the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cand_valid | input | 1 | Distributor has a pending candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_src | input | 3 | Source CPU of a software-generated candidate |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 mask, 2 acknowledge, 3 completion |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |
| take_o | output | 1 | Candidate accepted as active this cycle |
| take_id_o | output | 10 | ID of the accepted candidate |
| done_o | output | 1 | Active interrupt retired this cycle |
| done_id_o | output | 10 | ID of the retired interrupt |

## Verification
A vector table drives the qualification logic with an idle stack. It sweeps the mask just above, equal to and below the candidate priority, the enable bit, the valid flag, and IDs at the 1019/1020 boundary, so each gating term is shown to act on its own. Directed sequences then nest a shared interrupt under a software-generated one. These sequences tell a correct last-in retirement apart from one that pops on any completion value, and a zeroed source field apart from a passed-through one. Filling the stack to its depth and reading while empty or disabled separate a real acknowledge from the spurious 1023 path.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;
    localparam int ID_W    = 10;
    localparam int SRC_W   = 3;
    localparam int PRIO_W  = 8;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;
    localparam int VAL_W   = ID_W + SRC_W;
    localparam int ID_LIMIT = 1020;
    localparam int SGI_LIMIT = 16;
    localparam logic [ID_W-1:0]   SPURIOUS_ID = '1;
    localparam logic [PRIO_W-1:0] IDLE_PRIO   = '1;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_MASK = 2'd1,
        A_ACK  = 2'd2,
        A_DONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [SRC_W-1:0]  src;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } act_ent_t;
endpackage

// File: rtl/cpu_irq_qualify.sv
module cpu_irq_qualify
    import cpu_irq_pkg::*;
(
    input  logic              en,
    input  logic [PRIO_W-1:0] mask,
    input  logic [PRIO_W-1:0] run_prio,
    input  logic              room,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    output logic              hit
);
    logic id_ok, mask_ok, run_ok;

    always_comb begin
        id_ok   = (32'(cand_id) < ID_LIMIT);
        mask_ok = (cand_prio < mask);
        run_ok  = (cand_prio < run_prio);
        hit     = en && cand_valid && id_ok && mask_ok && run_ok && room;
    end
endmodule

// File: rtl/cpu_irq_stack.sv
module cpu_irq_stack
    import cpu_irq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  act_ent_t          push_ent,
    input  logic              pop,
    output act_ent_t          top_ent,
    output logic              empty,
    output logic              full,
    output logic [PRIO_W-1:0] run_prio
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        act_ent_t [DEPTH-1:0] ent;
        logic [CW-1:0]        cnt;
    } stk_t;

    stk_t s_d, s_q;
    logic [CW-1:0] top_idx;

    always_comb begin
        s_d     = s_q;
        empty   = (s_q.cnt == '0);
        full    = (32'(s_q.cnt) == DEPTH);
        top_idx = empty ? '0 : s_q.cnt - 1'b1;
        top_ent = s_q.ent[top_idx];
        run_prio = empty ? IDLE_PRIO : top_ent.prio;
        if (push && !full) begin
            s_d.ent[s_q.cnt] = push_ent;
            s_d.cnt          = s_q.cnt + 1'b1;
        end else if (pop && !empty) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R8
    pop_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (s_q.cnt == $past(s_q.cnt) - 1'b1));
endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
    import cpu_irq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [SRC_W-1:0]  cand_src,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              take_o,
    output logic [ID_W-1:0]   take_id_o,
    output logic              done_o,
    output logic [ID_W-1:0]   done_id_o
);
    typedef struct packed {
        logic              en;
        logic [PRIO_W-1:0] mask;
        logic [DATA_W-1:0] rdata;
    } reg_t;

    reg_t r_d, r_q;

    act_ent_t          top_ent, new_ent;
    logic              empty, full, hit;
    logic [PRIO_W-1:0] run_prio;
    logic              ack_rd, eoi_wr, eoi_match;
    logic [DATA_W-1:0] ack_val;

    cpu_irq_qualify u_qual (
        .en         (r_q.en),
        .mask       (r_q.mask),
        .run_prio   (run_prio),
        .room       (!full),
        .cand_valid (cand_valid),
        .cand_id    (cand_id),
        .cand_prio  (cand_prio),
        .hit        (hit)
    );

    cpu_irq_stack #(.DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take_o),
        .push_ent (new_ent),
        .pop      (done_o),
        .top_ent  (top_ent),
        .empty    (empty),
        .full     (full),
        .run_prio (run_prio)
    );

    always_comb begin
        r_d = r_q;

        new_ent.id   = cand_id;
        new_ent.src  = (32'(cand_id) < SGI_LIMIT) ? cand_src : '0;
        new_ent.prio = cand_prio;

        ack_rd  = reg_rd && (reg_addr == A_ACK);
        eoi_wr  = reg_wr && (reg_addr == A_DONE);
        ack_val = hit ? DATA_W'({new_ent.src, new_ent.id}) : DATA_W'(SPURIOUS_ID);

        eoi_match = eoi_wr && !empty
                 && (reg_wdata[VAL_W-1:0] == {top_ent.src, top_ent.id})
                 && (reg_wdata[DATA_W-1:VAL_W] == '0);

        take_o    = ack_rd && hit;
        take_id_o = cand_id;
        done_o    = eoi_match;
        done_id_o = top_ent.id;
        irq_o     = hit;

        if (reg_wr) begin
            case (reg_addr)
                A_CTRL:  r_d.en   = reg_wdata[0];
                A_MASK:  r_d.mask = reg_wdata[PRIO_W-1:0];
                default: ;
            endcase
        end
        if (reg_rd) begin
            case (reg_addr)
                A_CTRL:  r_d.rdata = DATA_W'(r_q.en);
                A_MASK:  r_d.rdata = DATA_W'(r_q.mask);
                A_ACK:   r_d.rdata = ack_val;
                default: r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign reg_rdata = r_q.rdata;

    // R5
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> r_q.en);

    // R4
    irq_under_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cand_prio < r_q.mask));

    // R2
    spurious_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !hit && !reg_wr) |=> $stable(run_prio));

    // R7
    take_raises_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (run_prio == $past(cand_prio)));
endmodule

// File: tb/cpu_irq_iface_bench.sv
module cpu_irq_iface_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cand_valid = 1'b0;
    logic [9:0]  cand_id = '0;
    logic [2:0]  cand_src = '0;
    logic [7:0]  cand_prio = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o, take_o, done_o;
    logic [9:0]  take_id_o, done_id_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cpu_irq_iface u_cpu_irq_iface (
        .clk(clk), .rst_n(rst_n),
        .cand_valid(cand_valid), .cand_id(cand_id), .cand_src(cand_src), .cand_prio(cand_prio),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o), .take_o(take_o), .take_id_o(take_id_o),
        .done_o(done_o), .done_id_o(done_id_o)
    );

    // {en, mask[7:0], valid, id[9:0], prio[7:0], expected irq}
    localparam int NV = 9;
    localparam logic [28:0] VEC [NV] = '{
        {1'b1, 8'hF0, 1'b1, 10'd40,   8'hA0, 1'b1},  // R4 0xF0 admits 0xA0
        {1'b1, 8'hA0, 1'b1, 10'd40,   8'hA0, 1'b0},  // R4 equal rejected
        {1'b1, 8'hA1, 1'b1, 10'd40,   8'hA0, 1'b1},  // R4 just above
        {1'b0, 8'hF0, 1'b1, 10'd40,   8'hA0, 1'b0},  // R5 disabled
        {1'b1, 8'hF0, 1'b0, 10'd40,   8'h10, 1'b0},  // R6 no valid
        {1'b1, 8'hFF, 1'b1, 10'd1020, 8'h00, 1'b0},  // R3 reserved id
        {1'b1, 8'hFF, 1'b1, 10'd1019, 8'h00, 1'b1},  // R3 top valid id
        {1'b1, 8'h00, 1'b1, 10'd5,    8'h00, 1'b0},  // R4 mask zero
        {1'b1, 8'hFF, 1'b1, 10'd77,   8'hFE, 1'b1}   // R6 below idle
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic cand(input logic v, input logic [9:0] id, input logic [2:0] s, input logic [7:0] p);
        @(negedge clk);
        cand_valid = v; cand_id = id; cand_src = s; cand_prio = p;
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic took;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 irq", 32'(irq_o), 0);
        chk("R11 rdata", reg_rdata, 0);
        rst_n = 1'b1;
        rd(2'd0, v); chk("R11 enable", v, 0);
        rd(2'd1, v); chk("R11 mask", v, 0);

        for (int i = 0; i < NV; i++) begin
            wr(2'd0, 32'(VEC[i][28]));
            wr(2'd1, 32'(VEC[i][27:20]));
            cand(VEC[i][19], VEC[i][18:9], 3'd0, VEC[i][8:1]);
            chk($sformatf("R4/R5/R6/R3 vec%0d", i), 32'(irq_o), 32'(VEC[i][0]));
        end

        // R12 readback
        wr(2'd0, 32'hFFFF_FFFF); wr(2'd1, 32'h0000_12F0);
        rd(2'd0, v); chk("R12 ctrl", v, 32'h1);
        rd(2'd1, v); chk("R12 mask", v, 32'hF0);
        rd(2'd3, v); chk("R12 done addr", v, 0);

        // R1 shared id, source zeroed; R7 take pulse
        cand(1'b1, 10'd40, 3'd5, 8'hA0);
        @(negedge clk); reg_rd = 1'b1; reg_addr = 2'd2; #1;
        took = take_o;
        chk("R7 take pulse", 32'(took), 1);
        chk("R7 take id", 32'(take_id_o), 40);
        @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
        chk("R1 shared ack", v, 32'h028);
        #1 chk("R7 same prio blocked", 32'(irq_o), 0);

        // R6 preempt with SGI, R1 source field
        cand(1'b1, 10'd3, 3'd5, 8'h80);
        chk("R6 preempt irq", 32'(irq_o), 1);
        rd(2'd2, v); chk("R1 sgi ack", v, 32'h1403);

        // R9 wrong value ignored
        wr(2'd3, 32'h028);
        cand(1'b1, 10'd50, 3'd0, 8'h90);
        chk("R9 mismatch ignored", 32'(irq_o), 0);
        wr(2'd3, 32'h0000_2000 | 32'h1403);
        #1 chk("R9 high bits ignored", 32'(irq_o), 0);
        // R8 retire restores A0
        @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 32'h1403; #1;
        chk("R8 done pulse", 32'(done_o), 1);
        chk("R8 done id", 32'(done_id_o), 3);
        @(negedge clk); reg_wr = 1'b0; #1;
        chk("R8 restored", 32'(irq_o), 1);
        wr(2'd3, 32'h028);
        cand(1'b1, 10'd40, 3'd0, 8'hA0);
        chk("R8 idle again", 32'(irq_o), 1);

        // R9 completion while empty
        wr(2'd3, 32'h028);
        chk("R9 empty ignored", 32'(irq_o), 1);

        // R10 depth
        for (int k = 0; k < 4; k++) begin
            cand(1'b1, 10'(100 + k), 3'd0, 8'(8'h70 - 8'(k * 16)));
            rd(2'd2, v);
            chk("R10 fill ack", v, 32'(100 + k));
        end
        cand(1'b1, 10'd200, 3'd0, 8'h10);
        chk("R10 full irq", 32'(irq_o), 0);
        rd(2'd2, v); chk("R10 full spurious", v, 32'h3FF);
        for (int k = 3; k >= 0; k--) wr(2'd3, 32'(100 + k));
        cand(1'b1, 10'd200, 3'd0, 8'hEF);
        chk("R10 drained", 32'(irq_o), 1);

        // R2 spurious leaves state
        cand(1'b0, 10'd60, 3'd0, 8'h20);
        rd(2'd2, v); chk("R2 spurious", v, 32'h3FF);
        cand(1'b1, 10'd60, 3'd0, 8'hEF);
        chk("R2 no state change", 32'(irq_o), 1);

        // R3 reserved id acknowledge
        cand(1'b1, 10'd1021, 3'd0, 8'h00);
        rd(2'd2, v); chk("R3 reserved ack", v, 32'h3FF);

        // R5 disabled acknowledge
        wr(2'd0, 32'h0);
        cand(1'b1, 10'd60, 3'd0, 8'h20);
        chk("R5 disabled irq", 32'(irq_o), 0);
        rd(2'd2, v); chk("R5 disabled ack", v, 32'h3FF);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule